// File: doc/BRIEF.md
# Converter Read Sequencer

This block runs a memory-mapped, simultaneous-sampling analog-to-digital converter from a synchronous host. When the host pulses a trigger, the block captures the requested channel-group code and auxiliary-input select and drives them to the converter. It then issues a conversion start pulse, waits for the converter's busy line to fall and rise again, and reads back every result register that the group code enabled. The reads go over an active-low chip-select / read-strobe bus with a 2-bit register address.

Every interval of the read strobe is a parameter counted in host clock cycles. These intervals are the address setup, the strobe-low time, the strobe-high gap and the post-strobe hold. Each result leaves on a valid/ready stream. A result carries a channel tag and a flag on the last channel of the group. Its 12-bit value sits at the top of a wider word, so converter full scale lands on the host's fractional fixed-point range.

Top module: `adc_rd_ctrl`

## Requirements
- R1: The group code selects the reads and their order. Code 00 reads channels 1,2. Code 01 reads 1,2,3. Code 10 reads 0,1,2. Code 11 reads 0,1,2,3. Channels are always read in ascending order, and exactly one stream word is sent per channel.
- R2: Channel n (0 = first sampled input, 1 = second, 2 = third, 3 = auxiliary) is read at bus address n. The same n is the stream tag.
- R3: The group code and auxiliary select are latched when a trigger is accepted. The converter lines keep them until the next accepted trigger. They are stable for at least SETTLE_CYC cycles before the start pulse rises, and the start pulse is high for exactly START_CYC cycles.
- R4: No read strobe is issued before busy has fallen and then risen after the start pulse.
- R5: Chip select is low and the address is valid for exactly SU_CYC cycles before the strobe falls. Both are held for exactly HD_CYC cycles after the strobe rises. Chip select is low whenever the strobe is low.
- R6: The strobe is low for exactly LO_CYC cycles, and it stays high for at least HI_CYC cycles between reads. Data is sampled on the last low cycle.
- R7: The output word carries bus bits 11..1 in its top bits. The word bit for bus bit 0 is forced to zero, and all lower bits are zero.
- R8: A word with valid high keeps its data and tag until ready is high. The last flag is high only on the final channel of the group.
- R9: A trigger that arrives while a sequence is running is ignored and does not change the converter lines or add results. It sets a sticky overrun flag.
- R10: Reset clears the overrun flag and the latched code. It drives chip select and strobe high and start and valid low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_i | input | 1 | Conversion request pulse |
| mode_i | input | 2 | Channel-group code to use |
| aux_i | input | 2 | Auxiliary input select to use |
| cv_mode_o | output | 2 | Latched group code to converter |
| cv_auxsel_o | output | 2 | Latched auxiliary select to converter |
| cv_start_o | output | 1 | Conversion start pulse |
| cv_busy_i | input | 1 | Converter busy, low while converting |
| cv_cs_n_o | output | 1 | Chip select, active low |
| cv_rd_n_o | output | 1 | Read strobe, active low |
| cv_addr_o | output | 2 | Result register address |
| cv_data_i | input | DAT_W | Converter data bus |
| res_valid_o | output | 1 | Result word valid |
| res_ready_i | input | 1 | Result word accepted |
| res_data_o | output | OUT_W | Top-aligned result word |
| res_chan_o | output | 2 | Channel tag of the word |
| res_last_o | output | 1 | Final channel of the group |
| overrun_o | output | 1 | Sticky dropped-trigger flag |

## Verification
The latched code appears on the converter lines one cycle after the trigger is accepted. The start pulse follows SETTLE_CYC cycles later. Each stream word rises once the strobe-low and hold intervals have passed, and after an accepted word the next read begins HI_CYC cycles later. The bench samples every output at the falling clock edge and counts the cycles of each strobe interval and of the start pulse. It checks those counts against the exact parameter values, not against fixed delays. Stream words are checked when valid is seen, and again on every stalled cycle before ready is given.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_SETTLE,
      ST_START,
      ST_WBL,
      ST_WBH,
      ST_SU,
      ST_LO,
      ST_HD,
      ST_PUSH,
      ST_GAP
   } rd_state_e;

   localparam int unsigned CH_W = 2;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   // code bit 1 adds channel 0 in front, code bit 0 adds channel 3 at the end
   function automatic logic [CH_W-1:0] first_chan(input logic [1:0] code);
      return code[1] ? 2'd0 : 2'd1;
   endfunction

   function automatic logic [CH_W-1:0] last_chan(input logic [1:0] code);
      return code[0] ? 2'd3 : 2'd2;
   endfunction

endpackage

// File: rtl/adc_rd_sync.sv
module adc_rd_sync #(
   parameter int  STAGES  = 2,
   parameter bit  RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   if (STAGES < 0) begin : g_bad_stages
      $error("adc_rd_sync: STAGES must not be negative");
   end

   if (STAGES == 0) begin : g_bypass
      assign q_o = d_i;
   end else begin : g_chain
      logic [STAGES-1:0] sr_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sr_q <= {STAGES{RST_VAL}};
         else        sr_q <= {sr_q[STAGES-2+1-1 -: STAGES-1+1-1], d_i};
      end
      assign q_o = sr_q[STAGES-1];
   end

endmodule

// File: rtl/adc_rd_tmr.sv
module adc_rd_tmr #(
   parameter int CW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [CW-1:0] val_i,
   output logic          zero_o
);

   logic [CW-1:0] cnt_q;

   if (CW < 1) begin : g_bad_cw
      $error("adc_rd_tmr: CW must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load_i)         cnt_q <= val_i;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign zero_o = (cnt_q == '0);

   // R6 support: a loaded count never grows on its own
   a_r6_tmr_down: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i && $past(!load_i) |-> cnt_q <= $past(cnt_q));

endmodule

// File: rtl/adc_rd_chseq.sv
module adc_rd_chseq
   import adc_rd_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load_i,
   input  logic [1:0]      code_i,
   input  logic            step_i,
   output logic [CH_W-1:0] chan_o,
   output logic            last_o
);

   logic [CH_W-1:0] ch_q;
   logic [CH_W-1:0] end_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ch_q  <= '0;
         end_q <= '0;
      end else if (load_i) begin
         ch_q  <= first_chan(code_i);
         end_q <= last_chan(code_i);
      end else if (step_i) begin
         ch_q  <= ch_q + 1'b1;
      end
   end

   assign chan_o = ch_q;
   assign last_o = (ch_q == end_q);

   // R1: the channel never runs past the end of its group
   a_r1_chan_bound: assert property (@(posedge clk) disable iff (!rst_n)
      ch_q <= end_q);

   // R1: no advance is requested from the final channel
   a_r1_no_step_past: assert property (@(posedge clk) disable iff (!rst_n)
      step_i |-> !last_o);

endmodule

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl
   import adc_rd_pkg::*;
#(
   parameter int DAT_W      = 12,
   parameter int OUT_W      = 16,
   parameter bit MASK_LSB   = 1'b1,
   parameter int SETTLE_CYC = 4,
   parameter int START_CYC  = 2,
   parameter int SU_CYC     = 1,
   parameter int LO_CYC     = 7,
   parameter int HI_CYC     = 7,
   parameter int HD_CYC     = 1,
   parameter int SYNC_STG   = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             trig_i,
   input  logic [1:0]       mode_i,
   input  logic [1:0]       aux_i,
   output logic [1:0]       cv_mode_o,
   output logic [1:0]       cv_auxsel_o,
   output logic             cv_start_o,
   input  logic             cv_busy_i,
   output logic             cv_cs_n_o,
   output logic             cv_rd_n_o,
   output logic [1:0]       cv_addr_o,
   input  logic [DAT_W-1:0] cv_data_i,
   output logic             res_valid_o,
   input  logic             res_ready_i,
   output logic [OUT_W-1:0] res_data_o,
   output logic [1:0]       res_chan_o,
   output logic             res_last_o,
   output logic             overrun_o
);

   localparam int MAXC  = imax(imax(imax(SETTLE_CYC, START_CYC), imax(SU_CYC, LO_CYC)),
                               imax(HI_CYC, HD_CYC));
   localparam int CNT_W = $clog2(MAXC + 1);
   localparam int PAD_W = OUT_W - DAT_W;
   localparam logic [DAT_W-1:0] LSB_MASK = DAT_W'(MASK_LSB);

   // elaboration-time parameter checks
   if (SETTLE_CYC < 1 || START_CYC < 1 || SU_CYC < 1 ||
       LO_CYC < 1 || HI_CYC < 1 || HD_CYC < 1) begin : g_bad_timing
      $error("adc_rd_ctrl: every timing count must be at least 1");
   end
   if (DAT_W < 2) begin : g_bad_dat
      $error("adc_rd_ctrl: DAT_W must be at least 2");
   end
   if (OUT_W < DAT_W) begin : g_bad_out
      $error("adc_rd_ctrl: OUT_W must not be below DAT_W");
   end

   rd_state_e        state_q, state_d;
   logic             busy_s;
   logic             tm_load, tm_zero;
   logic [CNT_W-1:0] tm_val;
   logic [1:0]       code_q, aux_q;
   logic [DAT_W-1:0] data_q;
   logic             ovr_q;
   logic             eoc_q;
   logic             accept_trig;
   logic             step;
   logic [1:0]       chan;
   logic             is_last;

   adc_rd_sync #(.STAGES(SYNC_STG), .RST_VAL(1'b1)) i_busy_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (cv_busy_i),
      .q_o   (busy_s)
   );

   adc_rd_tmr #(.CW(CNT_W)) i_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (tm_load),
      .val_i  (tm_val),
      .zero_o (tm_zero)
   );

   assign accept_trig = trig_i && (state_q == ST_IDLE);
   assign step        = (state_q == ST_PUSH) && res_ready_i && !is_last;

   adc_rd_chseq i_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (accept_trig),
      .code_i (mode_i),
      .step_i (step),
      .chan_o (chan),
      .last_o (is_last)
   );

   // next state
   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:   if (trig_i)          state_d = ST_SETTLE;
         ST_SETTLE: if (tm_zero)         state_d = ST_START;
         ST_START:  if (tm_zero)         state_d = ST_WBL;
         ST_WBL:    if (!busy_s)         state_d = ST_WBH;
         ST_WBH:    if (busy_s)          state_d = ST_SU;
         ST_SU:     if (tm_zero)         state_d = ST_LO;
         ST_LO:     if (tm_zero)         state_d = ST_HD;
         ST_HD:     if (tm_zero)         state_d = ST_PUSH;
         ST_PUSH:   if (res_ready_i)     state_d = is_last ? ST_IDLE : ST_GAP;
         ST_GAP:    if (tm_zero)         state_d = ST_SU;
         default:                        state_d = ST_IDLE;
      endcase
   end

   // interval load on entry to a timed state
   always_comb begin
      tm_load = (state_d != state_q);
      unique case (state_d)
         ST_SETTLE: tm_val = CNT_W'(SETTLE_CYC - 1);
         ST_START:  tm_val = CNT_W'(START_CYC - 1);
         ST_SU:     tm_val = CNT_W'(SU_CYC - 1);
         ST_LO:     tm_val = CNT_W'(LO_CYC - 1);
         ST_HD:     tm_val = CNT_W'(HD_CYC - 1);
         ST_GAP:    tm_val = CNT_W'(HI_CYC - 1);
         default:   tm_val = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         code_q  <= '0;
         aux_q   <= '0;
         data_q  <= '0;
         ovr_q   <= 1'b0;
         eoc_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         if (accept_trig) begin
            code_q <= mode_i;
            aux_q  <= aux_i;
            eoc_q  <= 1'b0;
         end
         if (trig_i && state_q != ST_IDLE) ovr_q <= 1'b1;
         if (state_q == ST_WBH && busy_s)  eoc_q <= 1'b1;
         if (state_q == ST_LO && tm_zero)  data_q <= cv_data_i & ~LSB_MASK;
      end
   end

   assign cv_mode_o   = code_q;
   assign cv_auxsel_o = aux_q;
   assign cv_start_o  = (state_q == ST_START);
   assign cv_cs_n_o   = !(state_q == ST_SU || state_q == ST_LO || state_q == ST_HD);
   assign cv_rd_n_o   = (state_q != ST_LO);
   assign cv_addr_o   = chan;
   assign res_valid_o = (state_q == ST_PUSH);
   assign res_chan_o  = chan;
   assign res_last_o  = is_last;
   assign overrun_o   = ovr_q;

   if (PAD_W > 0) begin : g_pad
      assign res_data_o = {data_q, {PAD_W{1'b0}}};
   end else begin : g_nopad
      assign res_data_o = data_q;
   end

   // checks
   logic [CNT_W:0] lo_run_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          lo_run_q <= '0;
      else if (!cv_rd_n_o) lo_run_q <= lo_run_q + 1'b1;
      else                 lo_run_q <= '0;
   end

   // R3: converter code lines only move at an accepted trigger
   a_r3_code_held: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_IDLE && state_q != ST_SETTLE) |-> $stable(cv_mode_o) && $stable(cv_auxsel_o));

   // R4: strobe only after the end-of-conversion edge
   a_r4_no_early_read: assert property (@(posedge clk) disable iff (!rst_n)
      !cv_rd_n_o |-> eoc_q);

   // R5: select covers the strobe
   a_r5_cs_covers_rd: assert property (@(posedge clk) disable iff (!rst_n)
      !cv_rd_n_o |-> !cv_cs_n_o);

   // R5: address steady while selected
   a_r5_addr_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (!cv_cs_n_o && $past(!cv_cs_n_o)) |-> $stable(cv_addr_o));

   // R6: strobe low width
   a_r6_low_width: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cv_rd_n_o) |-> lo_run_q == (CNT_W+1)'(LO_CYC));

   // R8: stalled word is held
   a_r8_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid_o && !res_ready_i |=> res_valid_o && $stable(res_data_o) && $stable(res_chan_o));

   // R9: overrun is sticky
   a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      overrun_o |=> overrun_o);

endmodule

// File: tb/test_adc_rd_ctrl.sv
module test_adc_rd_ctrl;

   localparam int SETTLE = 3;
   localparam int STARTW = 2;
   localparam int SU     = 2;
   localparam int LO     = 7;
   localparam int HI     = 7;
   localparam int HD     = 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        trig_i = 1'b0;
   logic [1:0]  mode_i = 2'b00;
   logic [1:0]  aux_i = 2'b00;
   logic [1:0]  cv_mode_o, cv_auxsel_o, cv_addr_o, res_chan_o;
   logic        cv_start_o, cv_cs_n_o, cv_rd_n_o;
   logic        cv_busy_i = 1'b1;
   logic [11:0] cv_data_i;
   logic        res_valid_o, res_last_o, overrun_o;
   logic        res_ready_i = 1'b0;
   logic [15:0] res_data_o;

   int total = 0;
   int bad   = 0;
   logic [3:0] vec_tag = 4'd0;

   always #2 clk = ~clk;

   adc_rd_ctrl #(
      .DAT_W(12), .OUT_W(16), .MASK_LSB(1'b1),
      .SETTLE_CYC(SETTLE), .START_CYC(STARTW), .SU_CYC(SU),
      .LO_CYC(LO), .HI_CYC(HI), .HD_CYC(HD), .SYNC_STG(2)
   ) i_adc_rd_ctrl (
      .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .mode_i(mode_i), .aux_i(aux_i),
      .cv_mode_o(cv_mode_o), .cv_auxsel_o(cv_auxsel_o), .cv_start_o(cv_start_o),
      .cv_busy_i(cv_busy_i), .cv_cs_n_o(cv_cs_n_o), .cv_rd_n_o(cv_rd_n_o),
      .cv_addr_o(cv_addr_o), .cv_data_i(cv_data_i), .res_valid_o(res_valid_o),
      .res_ready_i(res_ready_i), .res_data_o(res_data_o), .res_chan_o(res_chan_o),
      .res_last_o(res_last_o), .overrun_o(overrun_o)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // converter model: bus value carries tag and address, bit 0 driven high
   assign cv_data_i = (!cv_cs_n_o && !cv_rd_n_o) ? {vec_tag, cv_addr_o, 5'b10110, 1'b1} : 12'h000;

   logic start_q = 1'b0;
   logic eoc = 1'b0;
   int   dly = 0;
   int   lowc = 0;
   always @(posedge clk) begin
      start_q <= cv_start_o;
      if (cv_start_o && !start_q) begin
         dly <= 3;
         eoc <= 1'b0;
      end else if (dly != 0) begin
         dly <= dly - 1;
         if (dly == 1) begin
            cv_busy_i <= 1'b0;
            lowc <= 10 * (2 + int'(cv_mode_o[0]) + int'(cv_mode_o[1]));
         end
      end else if (!cv_busy_i) begin
         if (lowc == 1) begin
            cv_busy_i <= 1'b1;
            eoc <= 1'b1;
         end
         lowc <= lowc - 1;
      end
   end

   // bus timing monitor, sampled away from the active edge
   logic rd_p = 1'b1, st_p = 1'b0, hd_on = 1'b0;
   logic [3:0] mode_p = 4'h0;
   int su_run = 0, lo_run = 0, hd_run = 0, hi_run = 1000, st_run = 0, mode_age = 0;
   always @(negedge clk) begin
      if (rst_n) begin
         if ({cv_mode_o, cv_auxsel_o} != mode_p) mode_age = 0; else mode_age++;
         mode_p = {cv_mode_o, cv_auxsel_o};
         if (cv_start_o && !st_p) chk(mode_age >= SETTLE, "R3 settle before start", mode_age, SETTLE);
         if (cv_start_o) st_run++;
         if (!cv_start_o && st_p) begin
            chk(st_run == STARTW, "R3 start width", st_run, STARTW);
            st_run = 0;
         end
         st_p = cv_start_o;
         if (!cv_rd_n_o && rd_p) begin
            chk(su_run == SU, "R5 setup", su_run, SU);
            chk(eoc, "R4 read after end of conversion", eoc, 1);
            chk(hi_run >= HI, "R6 high gap", hi_run, HI);
            lo_run = 0;
         end
         if (!cv_rd_n_o) chk(!cv_cs_n_o, "R5 select covers strobe", cv_cs_n_o, 0);
         if (!cv_rd_n_o) lo_run++;
         if (cv_rd_n_o && !rd_p) begin
            chk(lo_run == LO, "R6 low width", lo_run, LO);
            hd_on = 1'b1;
            hd_run = 0;
            hi_run = 0;
         end
         if (cv_rd_n_o) hi_run++;
         if (hd_on) begin
            if (!cv_cs_n_o) hd_run++;
            else begin
               chk(hd_run == HD, "R5 hold", hd_run, HD);
               hd_on = 1'b0;
            end
         end
         if (cv_cs_n_o || !cv_rd_n_o) su_run = 0;
         else if (!hd_on) su_run++;
         rd_p = cv_rd_n_o;
      end
   end

   function automatic int exp_n(input logic [1:0] m);
      return 2 + int'(m[0]) + int'(m[1]);
   endfunction

   function automatic logic [1:0] exp_ch(input logic [1:0] m, input int k);
      case (m)
         2'b00:   return (k == 0) ? 2'd1 : 2'd2;
         2'b01:   return 2'(k + 1);
         2'b10:   return 2'(k);
         default: return 2'(k);
      endcase
   endfunction

   task automatic fire(input logic [1:0] m, input logic [1:0] a);
      mode_i = m;
      aux_i  = a;
      @(negedge clk);
      trig_i = 1'b1;
      @(negedge clk);
      trig_i = 1'b0;
   endtask

   task automatic collect(input logic [1:0] m, input int stall);
      int k = 0, left = 0, guard = 0;
      bit have = 0;
      logic [15:0] sv_d = '0;
      logic [1:0] sv_c = '0;
      logic [15:0] ew;
      while (k < exp_n(m) && guard < 3000) begin
         @(negedge clk);
         guard++;
         res_ready_i = 1'b0;
         if (res_valid_o) begin
            if (!have) begin
               have = 1;
               sv_d = res_data_o;
               sv_c = res_chan_o;
               left = stall;
            end else begin
               chk(res_data_o == sv_d && res_chan_o == sv_c, "R8 stalled word held", res_data_o, sv_d);
            end
            if (left > 0) left--;
            else begin
               ew = {vec_tag, exp_ch(m, k), 5'b10110, 1'b0, 4'b0000};
               chk(res_chan_o == exp_ch(m, k), "R1 channel order", res_chan_o, exp_ch(m, k));
               chk(res_data_o == ew, "R2 R7 word value", res_data_o, ew);
               chk(res_last_o == (k == exp_n(m) - 1), "R8 last flag", res_last_o, (k == exp_n(m) - 1));
               res_ready_i = 1'b1;
               have = 0;
               k++;
            end
         end
      end
      @(negedge clk);
      res_ready_i = 1'b0;
      chk(k == exp_n(m), "R1 word count", k, exp_n(m));
      repeat (5) @(negedge clk);
      chk(!res_valid_o, "R1 no extra word", res_valid_o, 0);
   endtask

   // {code, aux select, stall cycles}
   localparam logic [7:0] VEC [8] = '{
      {2'b00, 2'b01, 4'd0}, {2'b01, 2'b10, 4'd1}, {2'b10, 2'b11, 4'd0}, {2'b11, 2'b00, 4'd2},
      {2'b11, 2'b11, 4'd0}, {2'b10, 2'b00, 4'd3}, {2'b01, 2'b01, 4'd0}, {2'b00, 2'b10, 4'd1}
   };

   initial begin
      repeat (3) @(negedge clk);
      // R10 reset state
      chk(cv_cs_n_o && cv_rd_n_o, "R10 strobes idle", {cv_cs_n_o, cv_rd_n_o}, 2'b11);
      chk(!cv_start_o && !res_valid_o, "R10 start/valid low", {cv_start_o, res_valid_o}, 0);
      chk(!overrun_o && cv_mode_o == 2'b00, "R10 overrun/code clear", {overrun_o, cv_mode_o}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      for (int i = 0; i < 8; i++) begin
         vec_tag = 4'(i);
         fire(VEC[i][7:6], VEC[i][5:4]);
         chk(cv_mode_o == VEC[i][7:6] && cv_auxsel_o == VEC[i][5:4], "R3 code latched",
             {cv_mode_o, cv_auxsel_o}, VEC[i][7:4]);
         collect(VEC[i][7:6], int'(VEC[i][3:0]));
         chk(!overrun_o, "R9 no overrun on clean runs", overrun_o, 0);
      end

      // R9: trigger during a sequence is dropped
      vec_tag = 4'hA;
      fire(2'b11, 2'b10);
      repeat (15) @(negedge clk);
      mode_i = 2'b00;
      aux_i  = 2'b01;
      trig_i = 1'b1;
      @(negedge clk);
      trig_i = 1'b0;
      chk(cv_mode_o == 2'b11 && cv_auxsel_o == 2'b10, "R9 lines unchanged",
          {cv_mode_o, cv_auxsel_o}, 4'b1110);
      chk(overrun_o, "R9 overrun set", overrun_o, 1);
      collect(2'b11, 0);
      begin
         int extra = 0;
         for (int c = 0; c < 150; c++) begin
            @(negedge clk);
            if (res_valid_o || cv_start_o) extra++;
         end
         chk(extra == 0, "R9 dropped trigger gives no sequence", extra, 0);
      end
      chk(overrun_o, "R9 overrun sticky", overrun_o, 1);

      // R10: reset clears overrun
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      chk(!overrun_o, "R10 reset clears overrun", overrun_o, 0);
      rst_n = 1'b1;
      @(negedge clk);
      vec_tag = 4'h5;
      fire(2'b01, 2'b11);
      collect(2'b01, 1);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog actual=expired expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule